// File: doc/BRIEF.md
# Dark Column Reference Clamp

This block sets the black level of a sensor read-out line from the light-shielded reference columns at one edge of the line and removes it from the image pixels. Pixels arrive one per accepted transfer, each with a region tag that says whether it is a leading dummy phase, a shielded reference column, an unshielded buffer column, an active image column or a horizontal overclock sample. A separate flag marks pixels that belong to the shielded rows at the top and bottom of the frame. Those rows are not fully dark, so they never affect the level and produce no output.

Within each line the shielded columns are numbered in arrival order. The first column and any column after the twenty-first are skipped, because light can leak into the outer columns of the band. The twenty columns in between are summed. The block divides the sum by twenty with a fixed-point reciprocal and rounds to nearest. The result becomes the black level as soon as the last of the twenty samples has been taken. Every later buffer or active pixel has this level subtracted, and the result floors at zero. With the band on the leading edge, the line is corrected with its own level. With the band on the trailing edge, the line uses the level of the line before it.

A line that ends with fewer than twenty usable reference samples leaves the level unchanged and sets a sticky error flag. Both streams use valid/ready. Input is accepted whenever the single output register is empty or is being drained in the same cycle. Output data and its tag stay frozen while the output is valid and not accepted. Pixels that produce no output are still consumed only when `in_ready` is high.

Top module: `dark_ref_clamp`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_is_buffer` hold their values.
- R2: Only pixels tagged buffer (3'd2) or active (3'd3) in a non-shielded row produce an output, one cycle after acceptance, with `out_is_buffer` = 1 for buffer pixels. Dummy (3'd0), dark (3'd1) and overclock (3'd4) pixels are consumed without output.
- R3: Only dark-tagged pixels contribute to the level. Within a line they are counted from 0 in arrival order, and only positions 1 to 20 contribute. Position 0 and positions 21 and above are ignored.
- R4: The black level becomes (S + 10) / 20 in integer arithmetic, where S is the sum of the 20 contributing samples. It is visible on `black_level` in the cycle after the 20th sample is accepted, and it applies to every image pixel accepted after that.
- R5: An output pixel equals max(pixel − black_level, 0), using the level held at the moment the pixel is accepted.
- R6: Pixels accepted with `in_shield_row` = 1 produce no output and change neither the black level nor the error flag, including on `in_last`.
- R7: When a non-shielded line ends (`in_last` accepted) with fewer than 20 contributing samples, `black_level` keeps its value and `ref_err` rises in the next cycle. `ref_err` then stays high until reset.
- R8: After reset, `out_valid` = 0, `black_level` = 0 and `ref_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | W | Digitized pixel value |
| in_tag | input | 3 | Region tag: 0 dummy, 1 dark, 2 buffer, 3 active, 4 overclock |
| in_shield_row | input | 1 | Pixel belongs to a shielded top/bottom row |
| in_last | input | 1 | Last pixel of the line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | W | Black-level corrected pixel |
| out_is_buffer | output | 1 | Output pixel came from a buffer column |
| black_level | output | W | Current black level |
| ref_err | output | 1 | Sticky: a line lacked full reference data |

## Verification
The reference model is tried on several kinds of line. Leading-band lines with bright outer reference columns show whether the edge columns are excluded. Trailing-band lines show whether the previous level is used before the new one arrives. Lines with more than 22 dark samples check the upper cut-off. Fixed sums with remainders of 9 and 10 separate round-to-nearest from truncation. Shielded rows carrying dark values, short lines and an output that stalls every third cycle test, in turn, that shielded rows are ignored, that the level is held when reference data is missing, and that back-pressure leaves no gaps in the output.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    TAG_DUMMY = 3'd0,
    TAG_DARK  = 3'd1,
    TAG_BUF   = 3'd2,
    TAG_ACT   = 3'd3,
    TAG_OVCLK = 3'd4
  } pix_tag_e;
endpackage

// File: rtl/dcc_ref_accum.sv
// Counts shielded columns of a line, sums the inner window and flags
// the sample that completes it, or a line that ends short of it.
module dcc_ref_accum #(
  parameter int W         = 12,
  parameter int DARK_COLS = 22,
  parameter int EDGE_SKIP = 1,
  parameter int NREF      = 20
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           take,
  input  logic                           is_dark,
  input  logic                           last,
  input  logic [W-1:0]                   pix,
  output logic                           done,
  output logic                           short_line,
  output logic [W+$clog2(NREF)-1:0]      sum_o
);
  localparam int SUMW = W + $clog2(NREF);
  localparam int IDXW = $clog2(DARK_COLS + 1);

  logic [IDXW-1:0] idx_q;
  logic [SUMW-1:0] acc_q;
  logic            ok_q;
  logic            inner;

  assign inner      = (idx_q >= IDXW'(EDGE_SKIP)) && (idx_q < IDXW'(EDGE_SKIP + NREF));
  assign sum_o      = acc_q + SUMW'(pix);
  assign done       = take && is_dark && (idx_q == IDXW'(EDGE_SKIP + NREF - 1));
  assign short_line = take && last && !(ok_q || done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
      ok_q  <= 1'b0;
    end else if (take) begin
      if (last) begin
        idx_q <= '0;
        acc_q <= '0;
        ok_q  <= 1'b0;
      end else begin
        if (is_dark) begin
          if (idx_q != IDXW'(DARK_COLS)) idx_q <= idx_q + 1'b1;
          if (inner) acc_q <= sum_o;
        end
        if (done) ok_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcc_recip_avg.sv
// Rounded division by NREF through a multiply by a fixed-point reciprocal,
// exact over the full sum range.
module dcc_recip_avg #(
  parameter int W    = 12,
  parameter int NREF = 20
) (
  input  logic [W+$clog2(NREF)-1:0] sum_i,
  output logic [W-1:0]              avg_o
);
  localparam int SUMW = W + $clog2(NREF);
  localparam int SH   = SUMW + $clog2(NREF);
  localparam logic [SH:0] RECIP = (SH+1)'(((2**SH) + NREF - 1) / NREF);

  logic [SUMW-1:0]    biased;
  logic [SUMW+SH:0]   prod;

  assign biased = sum_i + SUMW'(NREF / 2);
  assign prod   = {{(SH+1){1'b0}}, biased} * {{SUMW{1'b0}}, RECIP};
  assign avg_o  = W'(prod >> SH);
endmodule

// File: rtl/dcc_clamp_out.sv
// Output register: subtracts the black level and floors at zero.
module dcc_clamp_out #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         load_buf,
  input  logic [W-1:0] pix,
  input  logic [W-1:0] level,
  input  logic         drain,
  output logic         ov,
  output logic [W-1:0] od,
  output logic         obuf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov   <= 1'b0;
      od   <= '0;
      obuf <= 1'b0;
    end else if (load) begin
      ov   <= 1'b1;
      od   <= (pix > level) ? (pix - level) : '0;
      obuf <= load_buf;
    end else if (drain) begin
      ov   <= 1'b0;
    end
  end
endmodule

// File: rtl/dark_ref_clamp.sv
module dark_ref_clamp
  import dcc_pkg::*;
#(
  parameter int W         = 12,
  parameter int DARK_COLS = 22,
  parameter int EDGE_SKIP = 1,
  parameter int NREF      = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic [2:0]   in_tag,
  input  logic         in_shield_row,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_is_buffer,
  output logic [W-1:0] black_level,
  output logic         ref_err
);
  localparam int SUMW = W + $clog2(NREF);

  logic            take, is_dark, is_image, load;
  logic            ref_done, ref_short;
  logic [SUMW-1:0] ref_sum;
  logic [W-1:0]    avg;
  logic [W-1:0]    level_q;
  logic            err_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready && !in_shield_row;
  assign is_dark  = (in_tag == TAG_DARK);
  assign is_image = (in_tag == TAG_BUF) || (in_tag == TAG_ACT);
  assign load     = take && is_image;

  dcc_ref_accum #(.W(W), .DARK_COLS(DARK_COLS), .EDGE_SKIP(EDGE_SKIP), .NREF(NREF)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .is_dark(is_dark), .last(in_last),
    .pix(in_data), .done(ref_done), .short_line(ref_short), .sum_o(ref_sum)
  );

  dcc_recip_avg #(.W(W), .NREF(NREF)) u_avg (.sum_i(ref_sum), .avg_o(avg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (ref_done)  level_q <= avg;
      if (ref_short) err_q   <= 1'b1;
    end
  end

  dcc_clamp_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .load_buf(in_tag == TAG_BUF),
    .pix(in_data), .level(level_q), .drain(out_ready),
    .ov(out_valid), .od(out_data), .obuf(out_is_buffer)
  );

  assign black_level = level_q;
  assign ref_err     = err_q;
endmodule

// File: rtl/dcc_clamp_chk.sv
module dcc_clamp_chk
  import dcc_pkg::*;
#(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_tag,
  input logic         in_shield_row,
  input logic         in_last,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_is_buffer,
  input logic [W-1:0] black_level,
  input logic         ref_err
);
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_buffer));

  p_ready_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_no_out_nonimage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && out_ready && !(in_tag == TAG_BUF || in_tag == TAG_ACT) |=> !out_valid);

  p_shield_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && out_ready && in_shield_row |=> !out_valid);

  p_level_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(black_level) |-> $past(in_valid && in_ready && in_tag == TAG_DARK && !in_shield_row));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err |=> ref_err);

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_err) |-> $past(in_valid && in_ready && in_last && !in_shield_row));
endmodule

bind dark_ref_clamp dcc_clamp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
  .in_shield_row(in_shield_row), .in_last(in_last), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_is_buffer(out_is_buffer),
  .black_level(black_level), .ref_err(ref_err)
);

// File: tb/test_dark_ref_clamp.sv
module test_dark_ref_clamp;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready, in_shield_row = 1'b0, in_last = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [2:0]   in_tag = '0;
  logic         out_valid, out_ready = 1'b1, out_is_buffer, ref_err;
  logic [W-1:0] out_data, black_level;

  always #2 clk = ~clk;

  dark_ref_clamp #(.W(W)) i_dark_ref_clamp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_tag(in_tag), .in_shield_row(in_shield_row), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_buffer(out_is_buffer), .black_level(black_level), .ref_err(ref_err)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  // behavioural model
  bit m_ov = 0, m_buf = 0, m_err = 0;
  int m_od = 0, m_lvl = 0, m_idx = 0, m_sum = 0, m_cnt = 0;
  bit stall_mode = 0, shield = 0;
  string lvl_req = "R4";
  int seed = 12345;

  function automatic int rnd(int m);
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >>> 8) % m;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One clock: drive, compare against the model, advance the model.
  task automatic step(bit v, int t, int d, bit last, output bit accepted);
    bit ordy;
    @(negedge clk);
    cyc++;
    ordy = stall_mode ? (cyc % 3 != 0) : 1'b1;
    in_valid = v; in_tag = 3'(t); in_data = W'(d); in_last = last;
    in_shield_row = shield; out_ready = ordy;
    #1;
    chk("R1", "in_ready", int'(in_ready), int'(!m_ov || ordy));
    chk("R2", "out_valid", int'(out_valid), int'(m_ov));
    if (m_ov) begin
      chk("R5", "out_data", int'(out_data), m_od);
      chk("R2", "out_is_buffer", int'(out_is_buffer), int'(m_buf));
    end
    chk(lvl_req, "black_level", int'(black_level), m_lvl);
    chk("R7", "ref_err", int'(ref_err), int'(m_err));
    accepted = v && (!m_ov || ordy);
    if (accepted && !shield && (t == 2 || t == 3)) begin
      m_ov = 1; m_buf = (t == 2);
      m_od = (d > m_lvl) ? d - m_lvl : 0;
    end else if (ordy) m_ov = 0;
    if (accepted && !shield) begin
      if (t == 1) begin
        if (m_idx >= 1 && m_idx <= 20) begin
          m_sum += d; m_cnt++;
          if (m_cnt == 20) m_lvl = (m_sum + 10) / 20;
        end
        m_idx++;
      end
      if (last) begin
        if (m_cnt < 20) m_err = 1;
        m_idx = 0; m_sum = 0; m_cnt = 0;
      end
    end
  endtask

  task automatic px(int t, int d, bit last);
    bit acc;
    do step(1'b1, t, d, last, acc); while (!acc);
  endtask

  task automatic idle(int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, acc);
  endtask

  // fixed >= 0: inner dark = 100, first inner one gets +fixed; else random.
  task automatic dark_band(int ndark, int fixed);
    for (int k = 0; k < ndark; k++) begin
      int v;
      if (k == 0 || k >= 21) v = 3000;
      else if (fixed >= 0) v = 100 + ((k == 1) ? fixed : 0);
      else v = 180 + rnd(64);
      px(1, v, 1'b0);
    end
  endtask

  task automatic image_part();
    for (int k = 0; k < 12; k++) px(2, 150 + rnd(200), 1'b0);
    for (int k = 0; k < 24; k++) px(3, (k % 3 == 0) ? rnd(300) : rnd(4096), 1'b0);
  endtask

  task automatic run_line(int ndark, bit right_band, int fixed);
    for (int k = 0; k < 11; k++) px(0, 4095, 1'b0);
    if (!right_band) begin dark_band(ndark, fixed); image_part(); end
    else begin image_part(); dark_band(ndark, fixed); end
    for (int k = 0; k < 4; k++) px(4, 4000, k == 3);
    idle(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R8", "reset out_valid", int'(out_valid), 0);
    chk("R8", "reset black_level", int'(black_level), 0);
    chk("R8", "reset ref_err", int'(ref_err), 0);
    rst_n = 1'b1;
    idle(2);
    lvl_req = "R3"; run_line(22, 1'b0, -1);
    run_line(26, 1'b0, -1);            // R3: samples past position 20 ignored
    lvl_req = "R4"; run_line(22, 1'b0, 10);  // R4: sum 2010 rounds up to 101
    run_line(22, 1'b0, 9);             // R4: sum 2009 rounds down to 100
    run_line(22, 1'b1, -1);            // R4: trailing band, previous level first
    stall_mode = 1; lvl_req = "R1";
    run_line(22, 1'b0, -1);            // R1: back-pressure
    run_line(22, 1'b1, -1);
    stall_mode = 0;
    shield = 1; lvl_req = "R6";
    run_line(22, 1'b0, 40);            // R6: shielded row, no effect
    run_line(5, 1'b0, -1);             // R6: short shielded row, no error
    shield = 0; lvl_req = "R7";
    run_line(15, 1'b0, -1);            // R7: short line, level held, error set
    run_line(22, 1'b0, -1);            // R7: error stays set
    idle(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule